// File: doc/BRIEF.md
# Indexed Coefficient Table Access Port

This block puts two small byte tables behind a narrow register bus: a 256-entry gamma curve table and a 32-entry coefficient table for a TV filter. Each table has three registers: a control byte, a pointer and a data window. A host sets the pointer once and then streams bytes through the data window. Every access to the window, read or write, moves the pointer to the next entry, so a whole table loads or dumps as one run of accesses at the same bus offset.

The two pointers behave differently at the end of their tables. The gamma pointer is a plain byte that rolls over from 255 back to 0. The filter pointer stops at the end of its table. Once it has reached 32 or more, window reads return zero, window writes are dropped, and the pointer does not move. The pixel datapaths that use these tables are outside this block.

Read data comes back from registers one clock after the access. Pointer updates and table writes take effect at the same clock edge as the access.

Top module: `itp_table_port`

## Requirements
- R1: A synchronous reset sets the gamma control byte to 0x00, the gamma pointer to 0x00, the filter control byte to 0x80 and the filter pointer to 0x00. `bus_rdata` reads 0x00 after reset.
- R2: The gamma control byte (offset 0) and the filter control byte (offset 3) are full 8-bit registers that can be read and written.
- R3: A write to the gamma pointer (offset 1) or the filter pointer (offset 4) loads the written byte into that pointer. A read of either offset returns the pointer. Neither access changes any table entry.
- R4: A read of the gamma window (offset 2) returns the entry at the gamma pointer. The pointer then advances by one, and 255 rolls over to 0.
- R5: A write to the gamma window stores the byte at the gamma pointer. The pointer then advances under the same roll-over rule as R4.
- R6: A read of the filter window (offset 5) while the filter pointer is below 32 returns that entry. The pointer then advances by one.
- R7: A read of the filter window while the filter pointer is 32 or more returns 0x00 and leaves the pointer unchanged.
- R8: A write to the filter window while the pointer is below 32 stores the byte and advances the pointer. While the pointer is 32 or more, the write is discarded and the pointer holds.
- R9: Read data appears on `bus_rdata` exactly one cycle after the read access. In any cycle after a cycle with no read, `bus_rdata` is 0x00. Offsets 6 and 7 read as 0x00 and ignore writes.
- R10: When `bus_rd` and `bus_wr` are both high, only the write is performed. The pointer advances at most once, and `bus_rdata` is 0x00 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after a read |

## Verification
On every cycle, the assertions check how each pointer moves after a window access: the gamma roll-over, and the filter advance below 32 and hold at 32 or above. They also check that a pointer write loads the bus byte, that a filter read past the end returns zero, and that `bus_rdata` is zero after any cycle without a pure read. The actual table contents can only be observed through the bench scenarios. These include streamed fills across the gamma roll-over and across the filter end, pointer reloads followed by readback, and a long random mix of accesses compared against a reference model of both tables and pointers.

// File: rtl/itp_pkg.sv
package itp_pkg;
  parameter int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_GCTL  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_GPTR  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_GDATA = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_FCTL  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_FPTR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_FDATA = 3'd5;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_REG,
    SRC_GAMMA,
    SRC_FILT
  } rd_src_e;
endpackage

// File: rtl/itp_table_ram.sv
// Simple dual-port table: one write port, one registered read port.
module itp_table_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/itp_index_ctr.sv
// Table pointer. BOUNDED=0: wraps at DEPTH-1. BOUNDED=1: freezes at DEPTH or above.
module itp_index_ctr #(
  parameter int IDX_W   = 8,
  parameter int DEPTH   = 256,
  parameter bit BOUNDED = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             in_range
);
  localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'(DEPTH);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH-1);

  logic [IDX_W-1:0] nxt;

  assign in_range = {1'b0, idx} < LIMIT;

  generate
    if (BOUNDED) begin : g_bounded
      always_comb nxt = in_range ? idx + 1'b1 : idx;
    end else begin : g_wrap
      always_comb nxt = (idx == LAST) ? '0 : idx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= load_val;
    else if (step) idx <= nxt;
  end
endmodule

// File: rtl/itp_table_port.sv
module itp_table_port
  import itp_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          GAMMA_DEPTH = 256,
  parameter int          FILT_DEPTH  = 32,
  parameter logic [7:0]  GCTL_RST    = 8'h00,
  parameter logic [7:0]  FCTL_RST    = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int GAW = $clog2(GAMMA_DEPTH);
  localparam int FAW = $clog2(FILT_DEPTH);

  logic              acc_rd, acc_wr, acc_any;
  logic              hit_gdata, hit_fdata;
  logic [DATA_W-1:0] gamma_idx, filt_idx;
  logic              gamma_ok, filt_ok;
  logic [DATA_W-1:0] gamma_q, filt_q;
  logic [DATA_W-1:0] gctl_q, fctl_q;
  logic [DATA_W-1:0] reg_q;
  rd_src_e           src_q;

  // Write wins when both strobes are high.
  assign acc_wr    = bus_wr;
  assign acc_rd    = bus_rd & ~bus_wr;
  assign acc_any   = bus_rd | bus_wr;
  assign hit_gdata = (bus_addr == OFF_GDATA);
  assign hit_fdata = (bus_addr == OFF_FDATA);

  itp_index_ctr #(.IDX_W(DATA_W), .DEPTH(GAMMA_DEPTH), .BOUNDED(1'b0)) u_gamma_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (acc_wr && bus_addr == OFF_GPTR),
    .load_val (bus_wdata),
    .step     (acc_any && hit_gdata),
    .idx      (gamma_idx),
    .in_range (gamma_ok)
  );

  itp_index_ctr #(.IDX_W(DATA_W), .DEPTH(FILT_DEPTH), .BOUNDED(1'b1)) u_filt_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (acc_wr && bus_addr == OFF_FPTR),
    .load_val (bus_wdata),
    .step     (acc_any && hit_fdata),
    .idx      (filt_idx),
    .in_range (filt_ok)
  );

  itp_table_ram #(.DEPTH(GAMMA_DEPTH), .DATA_W(DATA_W)) u_gamma_ram (
    .clk   (clk),
    .we    (acc_wr && hit_gdata && gamma_ok),
    .waddr (gamma_idx[GAW-1:0]),
    .wdata (bus_wdata),
    .re    (acc_rd && hit_gdata),
    .raddr (gamma_idx[GAW-1:0]),
    .rdata (gamma_q)
  );

  itp_table_ram #(.DEPTH(FILT_DEPTH), .DATA_W(DATA_W)) u_filt_ram (
    .clk   (clk),
    .we    (acc_wr && hit_fdata && filt_ok),
    .waddr (filt_idx[FAW-1:0]),
    .wdata (bus_wdata),
    .re    (acc_rd && hit_fdata && filt_ok),
    .raddr (filt_idx[FAW-1:0]),
    .rdata (filt_q)
  );

  // Control bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q <= DATA_W'(GCTL_RST);
      fctl_q <= DATA_W'(FCTL_RST);
    end else if (acc_wr) begin
      if (bus_addr == OFF_GCTL) gctl_q <= bus_wdata;
      if (bus_addr == OFF_FCTL) fctl_q <= bus_wdata;
    end
  end

  // Read source select, registered alongside the table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_NONE;
      reg_q <= '0;
    end else begin
      src_q <= SRC_NONE;
      reg_q <= '0;
      if (acc_rd) begin
        case (bus_addr)
          OFF_GCTL:  begin src_q <= SRC_REG; reg_q <= gctl_q;    end
          OFF_GPTR:  begin src_q <= SRC_REG; reg_q <= gamma_idx; end
          OFF_FCTL:  begin src_q <= SRC_REG; reg_q <= fctl_q;    end
          OFF_FPTR:  begin src_q <= SRC_REG; reg_q <= filt_idx;  end
          OFF_GDATA: src_q <= gamma_ok ? SRC_GAMMA : SRC_NONE;
          OFF_FDATA: src_q <= filt_ok ? SRC_FILT : SRC_NONE;
          default:   src_q <= SRC_NONE;
        endcase
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_REG:   bus_rdata = reg_q;
      SRC_GAMMA: bus_rdata = gamma_q;
      SRC_FILT:  bus_rdata = filt_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/itp_table_port_chk.sv
module itp_table_port_chk
  import itp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int GAMMA_DEPTH = 256,
  parameter int FILT_DEPTH  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] gamma_idx,
  input logic [DATA_W-1:0] filt_idx
);
  localparam logic [DATA_W-1:0] G_LAST = DATA_W'(GAMMA_DEPTH-1);
  localparam logic [DATA_W:0]   F_LIM  = (DATA_W+1)'(FILT_DEPTH);

  logic f_below;
  assign f_below = {1'b0, filt_idx} < F_LIM;

  // R1
  a_r1_reset_ptrs: assert property (@(posedge clk)
    rst |=> (gamma_idx == '0 && filt_idx == '0));

  // R3
  a_r3_gamma_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_GPTR) |=> gamma_idx == $past(bus_wdata));

  // R3
  a_r3_filt_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_FPTR) |=> filt_idx == $past(bus_wdata));

  // R4, R5
  a_r4_gamma_step: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr == OFF_GDATA) |=>
      gamma_idx == (($past(gamma_idx) == G_LAST) ? '0 : $past(gamma_idx) + 1'b1));

  // R6, R8
  a_r6_filt_step: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr == OFF_FDATA && f_below) |=>
      filt_idx == $past(filt_idx) + 1'b1);

  // R7, R8
  a_r7_filt_hold: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_addr == OFF_FDATA && !f_below) |=> $stable(filt_idx));

  // R7
  a_r7_filt_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == OFF_FDATA && !f_below) |=> bus_rdata == '0);

  // R9, R10
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || bus_wr) |=> bus_rdata == '0);
endmodule

bind itp_table_port itp_table_port_chk #(
  .DATA_W      (DATA_W),
  .GAMMA_DEPTH (GAMMA_DEPTH),
  .FILT_DEPTH  (FILT_DEPTH)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .gamma_idx (gamma_idx),
  .filt_idx  (filt_idx)
);

// File: tb/test_itp_table_port.sv
`timescale 1ns/1ps
module test_itp_table_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] m_g [256];
  logic [7:0] m_f [32];
  logic [7:0] m_gidx, m_fidx, m_gctl, m_fctl;

  always #5 clk = ~clk;

  itp_table_port i_itp_table_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  function automatic string pick_tag(input logic [2:0] a, input bit rd, input bit wr);
    if (rd && wr) return "R10";
    case (a)
      3'd0, 3'd3: return "R2";
      3'd1, 3'd4: return "R3";
      3'd2:       return wr ? "R5" : "R4";
      3'd5:       return wr ? "R8" : ((m_fidx < 8'd32) ? "R6" : "R7");
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [2:0] a, input bit rd, input bit wr,
                                       input logic [7:0] d);
    logic [7:0] r = 8'h00;
    bit rdo = rd && !wr;
    case (a)
      3'd0: begin if (rdo) r = m_gctl; if (wr) m_gctl = d; end
      3'd1: begin if (rdo) r = m_gidx; if (wr) m_gidx = d; end
      3'd2: begin
        if (rdo) r = m_g[m_gidx];
        if (wr) m_g[m_gidx] = d;
        if (rd || wr) m_gidx = m_gidx + 8'd1;
      end
      3'd3: begin if (rdo) r = m_fctl; if (wr) m_fctl = d; end
      3'd4: begin if (rdo) r = m_fidx; if (wr) m_fidx = d; end
      3'd5: if (m_fidx < 8'd32) begin
        if (rdo) r = m_f[m_fidx[4:0]];
        if (wr) m_f[m_fidx[4:0]] = d;
        if (rd || wr) m_fidx = m_fidx + 8'd1;
      end
      default: ;
    endcase
    return r;
  endfunction

  // Called at a falling edge; returns at the next falling edge with strobes cleared.
  task automatic acc(input logic [2:0] a, input bit rd, input bit wr,
                     input logic [7:0] d, input string tag = "");
    logic [7:0] exp;
    string t;
    t = (tag == "") ? pick_tag(a, rd, wr) : tag;
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    exp = model(a, rd, wr, d);
    @(posedge clk); #1;
    check(t, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_gidx = 8'h00; m_fidx = 8'h00; m_gctl = 8'h00; m_fctl = 8'h80;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", bus_rdata, 8'h00);
    acc(3'd0, 1, 0, 8'h00, "R1");
    acc(3'd1, 1, 0, 8'h00, "R1");
    acc(3'd3, 1, 0, 8'h00, "R1");
    acc(3'd4, 1, 0, 8'h00, "R1");

    // R5 fill the gamma table in one stream, R3 pointer readback after wrap
    for (int i = 0; i < 256; i++) acc(3'd2, 0, 1, 8'(i * 7 + 3));
    acc(3'd1, 1, 0, 8'h00, "R3");
    // R8 fill the filter table, pointer stops at 32
    for (int i = 0; i < 32; i++) acc(3'd5, 0, 1, 8'(8'hA0 ^ i));
    acc(3'd4, 1, 0, 8'h00, "R8");
    acc(3'd5, 0, 1, 8'h55, "R8");
    acc(3'd4, 1, 0, 8'h00, "R8");
    acc(3'd5, 1, 0, 8'h00, "R7");
    acc(3'd4, 1, 0, 8'h00, "R7");

    // R4 wrap across 255 -> 0
    acc(3'd1, 0, 1, 8'hFE, "R3");
    acc(3'd2, 1, 0, 8'h00, "R4");
    acc(3'd2, 1, 0, 8'h00, "R4");
    acc(3'd2, 1, 0, 8'h00, "R4");
    acc(3'd1, 1, 0, 8'h00, "R4");

    // R6 read the last filter entry, then run off the end
    acc(3'd4, 0, 1, 8'h1F, "R3");
    acc(3'd5, 1, 0, 8'h00, "R6");
    acc(3'd5, 1, 0, 8'h00, "R7");

    // R2 control bytes, R9 unmapped offsets, R10 both strobes
    acc(3'd0, 0, 1, 8'h3C, "R2");
    acc(3'd0, 1, 0, 8'h00, "R2");
    acc(3'd3, 0, 1, 8'h00, "R2");
    acc(3'd3, 1, 0, 8'h00, "R2");
    acc(3'd6, 0, 1, 8'hFF, "R9");
    acc(3'd6, 1, 0, 8'h00, "R9");
    acc(3'd7, 1, 0, 8'h00, "R9");
    acc(3'd1, 0, 1, 8'h10, "R3");
    acc(3'd2, 1, 1, 8'h99, "R10");
    acc(3'd1, 1, 0, 8'h00, "R10");
    acc(3'd2, 1, 0, 8'h00, "R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      int op;
      logic [7:0] d;
      a  = 3'($urandom_range(0, 7));
      op = int'($urandom_range(0, 9));
      d  = 8'($urandom_range(0, 255));
      if (a == 3'd4) d = 8'($urandom_range(24, 40));
      acc(a, op < 5 || op == 9, op >= 5, d);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0x00 expected=0x01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule